// File: doc/BRIEF.md
# PWM Input Capture Unit

This block measures an external pulse-width-modulated signal in timer ticks. A start strobe clears a prescaled free-running counter and arms two capture registers. One register takes the counter value on each rising edge of the chosen input pin. The other takes it on each falling edge. Every rising edge also stores both registers together as a snapshot pair. After the second pair is stored, the block reports two raw results: the period, measured rising edge to rising edge, and the high time, measured from the first rising edge to the latest falling edge. Both are given in counter ticks.

Software or a control sequencer sets the prescaler, the counter ceiling, a timeout in clock cycles, the pin select and a flag that says whether the second capture unit exists. It then pulses start and waits for the done pulse. If the second rising edge does not arrive in time, done comes with an error flag and zero results. The results are plain status outputs. They are held until the next start, so there is no back-pressure: a consumer reads them at any time after done.

Top module: `pwm_capture_unit`

## Requirements
- R1: A start pulse while idle raises busy on the next edge, clears period, duty and error to 0, restarts the counter and prescaler at 0, and latches prescaler, ceiling, timeout, pin select and unit flag for the whole measurement.
- R2: While busy, the counter advances once every psc+1 clock cycles. It counts 0, 1, ... up to the latched ceiling and then returns to 0. After k edges following the start edge it holds floor(k/(psc+1)) mod (ceiling+1).
- R3: Only the selected pin (select 0 gives pwm_i[0], select 1 gives pwm_i[1]) passes through a two-flop synchronizer and an edge detector. A level change first sampled at clock edge s captures the counter value held after edge s+1. Activity on the other pin has no effect.
- R4: With t0 and t2 the counts at the first and second rising edges, period is t2 - t0 when t2 >= t0, and ceiling - t0 + t2 otherwise.
- R5: With t1 the count of the latest falling edge captured before the second rising edge, duty is t1 - t0 when t1 >= t0, and ceiling - t0 + t1 otherwise.
- R6: When the unit flag is 0, duty is reported as 0.
- R7: If the duty from R5 exceeds the period, the period is subtracted from it once.
- R8: On the edge that captures the second rising edge, done is high for exactly one cycle, busy falls and the results update. They then hold until the next start.
- R9: If the second rising edge has not been captured by edge T after the start edge (T = timeout), then at edge T done pulses, error is set, and period and duty stay 0. A capture that happens on edge T itself wins over the timeout.
- R10: A start pulse while busy is ignored. The running measurement and its results are unaffected.
- R11: Pin edges while idle cause no capture and no done pulse, and leave the results unchanged. This includes edges after the second snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, acted on only while idle |
| psc_i | input | PSC_W | Prescaler; counter steps every psc_i+1 cycles |
| max_cnt_i | input | CNT_W | Counter ceiling |
| timeout_i | input | TMO_W | Timeout in clock cycles after the start edge |
| pin_sel_i | input | 1 | Chooses which input pin is measured |
| dual_unit_i | input | 1 | 1 when the falling-edge capture unit exists |
| pwm_i | input | 2 | Asynchronous PWM input pins |
| period_o | output | CNT_W | Raw period in ticks |
| duty_o | output | CNT_W | Raw high time in ticks |
| done_o | output | 1 | One-cycle end-of-measurement pulse |
| err_o | output | 1 | Timeout error, held until the next start |
| busy_o | output | 1 | Measurement in progress |

## Verification
The bench builds the block with an 8-bit counter, a 3-bit prescaler and a 12-bit timeout. With these widths, a ceiling drawn as low as 8 makes the counter wrap once or several times inside one measurement. That exercises the wrap formula and the duty-minus-period correction. Prescaler values up to 7 exercise the tick spacing. Timeouts placed one edge before and exactly on the completion edge test the priority of completion over timeout.

// File: rtl/pcu_pkg.sv
`timescale 1ns/1ps
package pcu_pkg;
  typedef enum logic [1:0] {
    PCU_IDLE        = 2'd0,
    PCU_SEEK_FIRST  = 2'd1,
    PCU_SEEK_SECOND = 2'd2
  } pcu_state_e;
endpackage

// File: rtl/pcu_timebase.sv
`timescale 1ns/1ps
module pcu_timebase #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [CNT_W-1:0] max_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [PSC_W-1:0] div_q;
  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step  = (div_q == psc_i);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (run_i) begin
      if (step) begin
        div_q <= '0;
        cnt_q <= (cnt_q >= max_i) ? '0 : cnt_q + 1'b1;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pcu_edge_sync.sv
`timescale 1ns/1ps
module pcu_edge_sync #(
  parameter int N_PIN = 2,
  parameter int SEL_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_PIN-1:0] pin_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             rise_o,
  output logic             fall_o
);
  logic [N_PIN-1:0] rise_v;
  logic [N_PIN-1:0] fall_v;

  for (genvar g = 0; g < N_PIN; g++) begin : g_pin
    // [0] first sync flop, [1] second sync flop, [2] previous level
    logic [2:0] sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[1:0], pin_i[g]};
    end
    assign rise_v[g] =  sh_q[1] & ~sh_q[2];
    assign fall_v[g] = ~sh_q[1] &  sh_q[2];
  end

  assign rise_o = rise_v[sel_i];
  assign fall_o = fall_v[sel_i];
endmodule

// File: rtl/pcu_calc.sv
`timescale 1ns/1ps
module pcu_calc #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] t0_i,
  input  logic [CNT_W-1:0] t1_i,
  input  logic [CNT_W-1:0] t2_i,
  input  logic [CNT_W-1:0] max_i,
  input  logic             dual_i,
  output logic [CNT_W-1:0] period_o,
  output logic [CNT_W-1:0] duty_o
);
  function automatic logic [CNT_W-1:0] span(input logic [CNT_W-1:0] a,
                                            input logic [CNT_W-1:0] b,
                                            input logic [CNT_W-1:0] m);
    if (b >= a) return b - a;
    else        return m - a + b;
  endfunction

  logic [CNT_W-1:0] per_w;
  logic [CNT_W-1:0] dty_raw;

  always_comb begin
    per_w    = span(t0_i, t2_i, max_i);
    dty_raw  = dual_i ? span(t0_i, t1_i, max_i) : '0;
    period_o = per_w;
    // falling-edge race: one extra period folded into the high time
    duty_o   = (dty_raw > per_w) ? dty_raw - per_w : dty_raw;
  end
endmodule

// File: rtl/pwm_capture_unit.sv
`timescale 1ns/1ps
module pwm_capture_unit
  import pcu_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 8,
  parameter int TMO_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [CNT_W-1:0] max_cnt_i,
  input  logic [TMO_W-1:0] timeout_i,
  input  logic             pin_sel_i,
  input  logic             dual_unit_i,
  input  logic [1:0]       pwm_i,
  output logic [CNT_W-1:0] period_o,
  output logic [CNT_W-1:0] duty_o,
  output logic             done_o,
  output logic             err_o,
  output logic             busy_o
);
  localparam int N_PIN = 2;
  localparam int SEL_W = 1;

  pcu_state_e       state_q;
  logic [PSC_W-1:0] psc_q;
  logic [CNT_W-1:0] max_q;
  logic [TMO_W-1:0] tlim_q;
  logic [TMO_W-1:0] tmo_q;
  logic             sel_q;
  logic             dual_q;
  logic [CNT_W-1:0] t0_q;
  logic [CNT_W-1:0] capb_q;
  logic [CNT_W-1:0] per_q;
  logic [CNT_W-1:0] dty_q;
  logic             done_q;
  logic             err_q;

  logic             launch;
  logic             running;
  logic             rise;
  logic             fall;
  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] calc_per;
  logic [CNT_W-1:0] calc_dty;
  logic             tmo_hit;

  assign running = (state_q != PCU_IDLE);
  assign launch  = (state_q == PCU_IDLE) && start_i;
  assign tmo_hit = (TMO_W'(tmo_q + 1'b1) == tlim_q);

  pcu_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_timebase (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (launch),
    .run_i   (running),
    .psc_i   (psc_q),
    .max_i   (max_q),
    .cnt_o   (cnt_w)
  );

  pcu_edge_sync #(.N_PIN(N_PIN), .SEL_W(SEL_W)) u_edges (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (pwm_i),
    .sel_i  (sel_q),
    .rise_o (rise),
    .fall_o (fall)
  );

  // second snapshot pair: A = live counter (t2), B = last falling capture (t1)
  pcu_calc #(.CNT_W(CNT_W)) u_calc (
    .t0_i     (t0_q),
    .t1_i     (capb_q),
    .t2_i     (cnt_w),
    .max_i    (max_q),
    .dual_i   (dual_q),
    .period_o (calc_per),
    .duty_o   (calc_dty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PCU_IDLE;
      psc_q   <= '0;
      max_q   <= '0;
      tlim_q  <= '0;
      tmo_q   <= '0;
      sel_q   <= 1'b0;
      dual_q  <= 1'b0;
      t0_q    <= '0;
      capb_q  <= '0;
      per_q   <= '0;
      dty_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state_q == PCU_IDLE) begin
        if (start_i) begin
          state_q <= PCU_SEEK_FIRST;
          psc_q   <= psc_i;
          max_q   <= max_cnt_i;
          tlim_q  <= timeout_i;
          sel_q   <= pin_sel_i;
          dual_q  <= dual_unit_i;
          tmo_q   <= '0;
          t0_q    <= '0;
          capb_q  <= '0;
          per_q   <= '0;
          dty_q   <= '0;
          err_q   <= 1'b0;
        end
      end else begin
        if (fall && dual_q) capb_q <= cnt_w;
        if ((state_q == PCU_SEEK_SECOND) && rise) begin
          per_q   <= calc_per;
          dty_q   <= calc_dty;
          done_q  <= 1'b1;
          state_q <= PCU_IDLE;
        end else if (tmo_hit) begin
          err_q   <= 1'b1;
          done_q  <= 1'b1;
          state_q <= PCU_IDLE;
        end else begin
          tmo_q <= tmo_q + 1'b1;
          if ((state_q == PCU_SEEK_FIRST) && rise) begin
            t0_q    <= cnt_w;
            state_q <= PCU_SEEK_SECOND;
          end
        end
      end
    end
  end

  assign period_o = per_q;
  assign duty_o   = dty_q;
  assign done_o   = done_q;
  assign err_o    = err_q;
  assign busy_o   = running;
endmodule

// File: rtl/pcu_checker.sv
`timescale 1ns/1ps
module pcu_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             done_o,
  input logic             err_o,
  input logic             busy_o,
  input logic [CNT_W-1:0] period_o,
  input logic [CNT_W-1:0] duty_o,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] max_q,
  input logic             dual_q
);
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (cnt <= max_q)); // R2
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (period_o == '0 && duty_o == '0 && !err_o)); // R1
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o); // R8
  AST_ERR_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (period_o == '0 && duty_o == '0)); // R9
  AST_SINGLE_UNIT_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !dual_q) |-> (duty_o == '0)); // R6
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(max_q)); // R10
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(period_o) && $stable(duty_o))); // R11
endmodule

bind pwm_capture_unit pcu_checker #(.CNT_W(CNT_W)) u_pcu_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .done_o   (done_o),
  .err_o    (err_o),
  .busy_o   (busy_o),
  .period_o (period_o),
  .duty_o   (duty_o),
  .cnt      (cnt_w),
  .max_q    (max_q),
  .dual_q   (dual_q)
);

// File: tb/pwm_capture_unit_tb_top.sv
`timescale 1ns/1ps
module pwm_capture_unit_tb_top;
  localparam int CNT_W = 8;
  localparam int PSC_W = 3;
  localparam int TMO_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [PSC_W-1:0] psc = '0;
  logic [CNT_W-1:0] maxc = '0;
  logic [TMO_W-1:0] tmo = '0;
  logic             sel = 1'b0;
  logic             dual = 1'b0;
  logic [1:0]       pins = '0;
  logic [CNT_W-1:0] per;
  logic [CNT_W-1:0] dty;
  logic             done;
  logic             err;
  logic             busy;

  int n_tests = 0;
  int n_fail  = 0;
  int n_done  = 0;

  always #2.5 clk = ~clk;

  pwm_capture_unit #(.CNT_W(CNT_W), .PSC_W(PSC_W), .TMO_W(TMO_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .psc_i(psc), .max_cnt_i(maxc),
    .timeout_i(tmo), .pin_sel_i(sel), .dual_unit_i(dual), .pwm_i(pins),
    .period_o(per), .duty_o(dty), .done_o(done), .err_o(err), .busy_o(busy)
  );

  always @(posedge clk) begin
    #1;
    if (done) n_done++;
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int tick_at(int k, int p, int m);
    return (k / (p + 1)) % (m + 1);
  endfunction

  function automatic int span(int a, int b, int m);
    return (b >= a) ? b - a : m - a + b;
  endfunction

  // lead/hi/lo in cycles; edges driven after edge k are captured with tick_at(k+2)
  task automatic meas(input int p, input int m, input int s, input int d,
                      input int lead, input int hi, input int lo, input int tl, input bit poke);
    int kr0, kf, kr2, ce, ende, t0, t1, t2, ep, ed, nd0;
    bit to;
    logic [CNT_W-1:0] hold_p, hold_d;
    kr0 = lead; kf = lead + hi; kr2 = lead + hi + lo; ce = kr2 + 3;
    t0 = tick_at(kr0 + 2, p, m);
    t1 = tick_at(kf + 2, p, m);
    t2 = tick_at(kr2 + 2, p, m);
    ep = span(t0, t2, m);
    ed = d ? span(t0, t1, m) : 0;
    if (ed > ep) ed = ed - ep;
    to = (tl < ce);
    ende = to ? tl : ce;
    @(negedge clk);
    psc = p[PSC_W-1:0]; maxc = m[CNT_W-1:0]; tmo = tl[TMO_W-1:0];
    sel = s[0]; dual = d[0]; pins[s] = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k <= ende + 1; k++) begin
      if (k > 0) @(negedge clk);
      if (k == 0) begin
        chk("R1", "busy after start", busy, 1);
        chk("R1", "period cleared", per, 0);
        chk("R1", "error cleared", err, 0);
      end
      if (ende >= 2 && k == ende - 1) chk("R8", "busy before end", busy, 1);
      if (k == ende) begin
        chk("R8", "done pulse", done, 1);
        chk("R8", "busy fell", busy, 0);
        chk("R9", "error flag", err, to);
        chk(d ? "R5" : "R6", "duty", dty, to ? 0 : ed);
        chk((m < 64) ? "R4" : "R2", "period", per, to ? 0 : ep);
      end
      if (k == ende + 1) chk("R8", "done one cycle", done, 0);
      pins[1-s] = 1'($urandom_range(0, 1));  // R3 other pin is noise
      start = poke && (k == kr0 + 1);        // R10 start while busy
      if (k == kr0) pins[s] = 1'b1;
      if (k == kf)  pins[s] = 1'b0;
      if (k == kr2) pins[s] = 1'b1;
    end
    start = 1'b0;
    nd0 = n_done; hold_p = per; hold_d = dty;
    for (int j = 0; j < 4; j++) begin
      repeat (3) @(negedge clk);
      pins[s] = ~pins[s];
    end
    pins[s] = 1'b0;
    repeat (5) @(negedge clk);
    chk("R11", "no done while idle", n_done, nd0);
    chk("R11", "period held", per, hold_p);
    chk("R11", "duty held", dty, hold_d);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    chk("R1", "reset busy", busy, 0);
    chk("R8", "reset done", done, 0);
    chk("R9", "reset error", err, 0);
    chk("R4", "reset period", per, 0);
    chk("R5", "reset duty", dty, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    meas(0, 255, 0, 1, 5, 7, 9, 4000, 0);   // R4 R5 basic
    meas(0, 255, 1, 1, 4, 12, 3, 4000, 0);  // R3 pin 1
    meas(0, 255, 0, 0, 3, 8, 8, 4000, 0);   // R6 single unit
    meas(0, 20, 0, 1, 3, 10, 10, 4000, 0);  // R4 wrap
    meas(0, 15, 1, 1, 1, 12, 6, 4000, 0);   // R7 race correction
    meas(3, 200, 0, 1, 2, 17, 23, 4000, 0); // R2 prescaler
    meas(0, 255, 0, 1, 4, 5, 5, 4000, 1);   // R10 start while busy
    meas(0, 255, 0, 1, 4, 5, 5, 16, 0);     // R9 timeout one edge early
    meas(0, 255, 0, 1, 4, 5, 5, 17, 0);     // R9 completion on timeout edge wins
    meas(1, 255, 1, 1, 40, 5, 5, 10, 0);    // R9 no edge before timeout
    for (int i = 0; i < 40; i++) begin
      int m;
      m = ($urandom_range(0, 1) == 1) ? int'($urandom_range(8, 40)) : int'($urandom_range(41, 255));
      meas(int'($urandom_range(0, 7)), m, int'($urandom_range(0, 1)), int'($urandom_range(0, 1)),
           int'($urandom_range(1, 8)), int'($urandom_range(1, 30)), int'($urandom_range(1, 30)),
           4000, bit'($urandom_range(0, 1)));
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule